// File: doc/BRIEF.md
# Outbound Message Descriptor Queue Controller

This block manages a circular ring of 32-byte transmit descriptors held in memory. Software sets up the ring base and size while the unit is off. Each time it adds a descriptor, it sets a command bit in the mode register, and that bit moves the enqueue pointer on by one slot. While the ring holds pending entries, the controller reads the pending descriptor at the dequeue pointer through a single-outstanding memory read port. It then offers the descriptor's source address, destination ID, mailbox number, attributes and transfer size to a transmitter over a valid/ready handshake.

When the transmitter takes the message, the dequeue pointer moves on by 32 bytes and an end-of-message flag is raised. If the transmitter reports an error, a transmission-error flag is raised instead. Both pointers wrap to the ring base after the last slot. The controller flags a queue that has just become full, an increment that arrives while the queue is full, and a queue that has drained. Every interrupt flag is cleared by writing a one to it, and the interrupt line is the OR of all the flags.

Top module: `omq_ctrl`

## Requirements
- R1: After reset the mode, status and both pointers read zero, and tx_valid, mem_req and irq are low.
- R2: A write to the ring base (wr_sel=2) loads the base and both pointers with the written value, with its low 5 bits cleared. This happens only while the unit is disabled; while it is enabled the write has no effect.
- R3: A mode write (wr_sel=0) sets the enable from bit 0 and the ring size field from bits 15:12. The ring holds 2^(field+2) entries, capped at 2048. Writing bit 1 = 1 together with bit 0 = 1 advances the enqueue pointer by 32 bytes. Bit 1 always reads 0, and an increment written with bit 0 = 0 is ignored.
- R4: A pointer that moves on from the last slot of the ring returns to the ring base.
- R5: The queue is full when one slot past the enqueue pointer equals the dequeue pointer. An increment while full sets the overflow flag (status bit 5) and leaves the enqueue pointer unchanged. An accepted increment that leaves the queue full sets the queue-full flag (status bit 4).
- R6: For each pending slot the controller reads the words at byte offsets 4, 8, 12 and 24 from the dequeue pointer. It presents them as tx_src_addr, tx_dest_id (bits 31:16 of the offset-8 word), tx_mbox (bits 1:0 of the offset-8 word), tx_attr and tx_size.
- R7: tx_valid stays high until tx_ready. On acceptance the dequeue pointer advances by 32 bytes. The acceptance sets end-of-message (status bit 1), or transmission error (status bit 7) when tx_err is high.
- R8: Busy (status bit 2) reads 1 exactly while the unit is enabled and the pointers differ. An acceptance that makes the dequeue pointer equal the enqueue pointer sets queue-empty (status bit 0).
- R9: A status write (wr_sel=1) clears each of bits 0, 1, 4, 5 and 7 that is written as 1; busy is unaffected.
- R10: irq is high exactly when any of status bits 0, 1, 4, 5 or 7 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 status, 2 ring base |
| wr_data | input | 32 | Register write data |
| mode_o | output | 32 | Mode register readback |
| status_o | output | 32 | Status register readback |
| enq_ptr_o | output | AW | Enqueue pointer |
| deq_ptr_o | output | AW | Dequeue pointer |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Descriptor word read request (one cycle) |
| mem_addr | output | AW | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Descriptor offered to transmitter |
| tx_ready | input | 1 | Transmitter accepts the message |
| tx_err | input | 1 | Transmitter reports an error with the acceptance |
| tx_src_addr | output | 32 | Source address word |
| tx_dest_id | output | 16 | Destination ID |
| tx_mbox | output | 2 | Mailbox number |
| tx_attr | output | 32 | Attribute word |
| tx_size | output | 32 | Transfer size word |

## Verification
Register writes, increments and acceptances take effect at the next rising edge, so pointers, status and irq are due one cycle after the stimulus. The bench drives every stimulus on a falling edge and compares against its own ring model on the following falling edge. The descriptor fetch takes a variable number of cycles, because it depends on memory latency: nine edges from an idle start with the bench's one-cycle memory. The bench therefore polls tx_valid on falling edges, checks the presented fields against a hash of the addresses it expects to be read, and only then raises tx_ready for one cycle. The hold of tx_valid is checked over several cycles with tx_ready low.

// File: rtl/omq_ctrl.sv
module omq_ctrl #(
  parameter int AW     = 32,
  parameter int MAXLOG = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [31:0]   mode_o,
  output logic [31:0]   status_o,
  output logic [AW-1:0] enq_ptr_o,
  output logic [AW-1:0] deq_ptr_o,
  output logic          irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic          tx_err,
  output logic [31:0]   tx_src_addr,
  output logic [15:0]   tx_dest_id,
  output logic [1:0]    tx_mbox,
  output logic [31:0]   tx_attr,
  output logic [31:0]   tx_size
);
  localparam int          SLOT_SH  = 5;
  localparam logic [7:0]  INT_MASK = 8'hB3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_SEND} fsm_t;

  fsm_t          state;
  logic [1:0]    wi;
  logic          en_q;
  logic [3:0]    szf_q;
  logic [AW-1:0] base_q, enq_q, deq_q;
  logic [7:0]    st_q;
  logic [31:0]   src_q, attr_q, size_q;
  logic [15:0]   dest_q;
  logic [1:0]    mbox_q;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p, input logic [AW-1:0] b,
                                             input logic [AW-1:0] m);
    return b + ((p - b + AW'(32)) & m);
  endfunction

  logic [4:0]    lg;
  logic [AW-1:0] ring_mask;
  assign lg        = (5'(szf_q) + 5'd2 > 5'(MAXLOG)) ? 5'(MAXLOG) : 5'(szf_q) + 5'd2;
  assign ring_mask = (AW'(1) << (lg + 5'(SLOT_SH))) - AW'(1);

  logic mode_wr, stat_wr, base_ld, stop, inc_req, full, inc_ok, done;
  logic [AW-1:0] enq_n, deq_n;
  logic [7:0] st_set, st_clr;

  assign mode_wr = wr_en && wr_sel == 2'd0;
  assign stat_wr = wr_en && wr_sel == 2'd1;
  assign base_ld = wr_en && wr_sel == 2'd2 && !en_q;
  assign stop    = mode_wr && !wr_data[0];
  assign inc_req = mode_wr && wr_data[1] && wr_data[0];
  assign full    = step_ptr(enq_q, base_q, ring_mask) == deq_q;
  assign inc_ok  = inc_req && !full;
  assign done    = state == S_SEND && tx_ready;
  assign enq_n   = inc_ok ? step_ptr(enq_q, base_q, ring_mask) : enq_q;
  assign deq_n   = done ? step_ptr(deq_q, base_q, ring_mask) : deq_q;

  always_comb begin
    st_set    = '0;
    st_set[0] = done && deq_n == enq_n;
    st_set[1] = done && !tx_err;
    st_set[4] = inc_ok && step_ptr(enq_n, base_q, ring_mask) == deq_n;
    st_set[5] = inc_req && full;
    st_set[7] = done && tx_err;
    st_clr    = stat_wr ? (wr_data[7:0] & INT_MASK) : 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; szf_q <= '0; base_q <= '0; enq_q <= '0; deq_q <= '0; st_q <= '0;
    end else begin
      if (mode_wr) begin
        en_q  <= wr_data[0];
        szf_q <= wr_data[15:12];
      end
      if (base_ld) begin
        base_q <= {wr_data[AW-1:SLOT_SH], SLOT_SH'(0)};
        enq_q  <= {wr_data[AW-1:SLOT_SH], SLOT_SH'(0)};
        deq_q  <= {wr_data[AW-1:SLOT_SH], SLOT_SH'(0)};
      end else begin
        enq_q <= enq_n;
        deq_q <= deq_n;
      end
      st_q <= (st_q & ~st_clr) | st_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; wi <= '0;
      src_q <= '0; dest_q <= '0; mbox_q <= '0; attr_q <= '0; size_q <= '0;
    end else if (stop) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (en_q && enq_q != deq_q) begin state <= S_REQ; wi <= '0; end
        S_REQ:  state <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          case (wi)
            2'd0: src_q <= mem_rdata;
            2'd1: begin dest_q <= mem_rdata[31:16]; mbox_q <= mem_rdata[1:0]; end
            2'd2: attr_q <= mem_rdata;
            default: size_q <= mem_rdata;
          endcase
          if (wi == 2'd3) state <= S_SEND;
          else begin wi <= wi + 2'd1; state <= S_REQ; end
        end
        default: if (tx_ready) state <= S_IDLE;
      endcase
    end
  end

  logic [AW-1:0] woff;
  always_comb
    case (wi)
      2'd0:    woff = AW'(4);
      2'd1:    woff = AW'(8);
      2'd2:    woff = AW'(12);
      default: woff = AW'(24);
    endcase

  assign mem_req     = state == S_REQ;
  assign mem_addr    = deq_q + woff;
  assign tx_valid    = state == S_SEND;
  assign tx_src_addr = src_q;
  assign tx_dest_id  = dest_q;
  assign tx_mbox     = mbox_q;
  assign tx_attr     = attr_q;
  assign tx_size     = size_q;
  assign mode_o      = {16'd0, szf_q, 10'd0, 1'b0, en_q};
  assign status_o    = {24'd0, st_q | {5'd0, en_q && enq_q != deq_q, 2'd0}};
  assign enq_ptr_o   = enq_q;
  assign deq_ptr_o   = deq_q;
  assign irq         = |st_q;

  assert_txvalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(wr_en && wr_sel == 2'd0 && !wr_data[0])) |=> tx_valid);
  assert_deq_moves_only_on_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(deq_q) |-> ($past(tx_valid && tx_ready) || $past(wr_en && wr_sel == 2'd2)));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[5]) |-> $stable(enq_q));
  assert_empty_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q[0]) |-> enq_q == deq_q);
  assert_offer_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (status_o[2] && enq_ptr_o != deq_ptr_o));
  assert_fetch_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mode_o[0]);
endmodule

// File: tb/omq_ctrl_tb.sv
`timescale 1ns/1ps
module omq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mem_rvalid = 0, tx_ready = 0, tx_err = 0;
  logic [1:0]  wr_sel = 0;
  logic [31:0] wr_data = 0, mem_rdata = 0;
  logic [31:0] mode_o, status_o, enq_ptr_o, deq_ptr_o, mem_addr;
  logic [31:0] tx_src_addr, tx_attr, tx_size;
  logic [15:0] tx_dest_id;
  logic [1:0]  tx_mbox;
  logic irq, mem_req, tx_valid;

  omq_ctrl u_dut (.clk, .rst_n, .wr_en, .wr_sel, .wr_data, .mode_o, .status_o,
    .enq_ptr_o, .deq_ptr_o, .irq, .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
    .tx_valid, .tx_ready, .tx_err, .tx_src_addr, .tx_dest_id, .tx_mbox, .tx_attr, .tx_size);

  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A50F1E;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= memf(mem_addr);
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic        men = 0;
  logic [3:0]  msz = 0;
  logic [31:0] mbase = 0, menq = 0, mdeq = 0;
  logic [7:0]  mst = 0;

  function automatic logic [31:0] mnxt(input logic [31:0] p);
    int lgv = (msz + 2 > 11) ? 11 : msz + 2;
    logic [31:0] m = (32'd1 << (lgv + 5)) - 1;
    return mbase + ((p - mbase + 32) & m);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic busy = men && menq != mdeq;
    chk({tag, " enq"}, enq_ptr_o, menq);
    chk({tag, " deq"}, deq_ptr_o, mdeq);
    chk({tag, " status"}, status_o, {24'd0, mst | {5'd0, busy, 2'd0}});
    chk({tag, " mode"}, mode_o, {16'd0, msz, 10'd0, 1'b0, men});
    chk({tag, " irq R10"}, {31'd0, irq}, {31'd0, |mst});
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d;
    case (s)
      2'd0: begin
        if (d[1] && d[0]) begin
          if (mnxt(menq) == mdeq) mst[5] = 1;
          else begin
            menq = mnxt(menq);
            if (mnxt(menq) == mdeq) mst[4] = 1;
          end
        end
        men = d[0]; msz = d[15:12];
      end
      2'd1: mst = mst & ~(d[7:0] & 8'hB3);
      default: if (!men) begin mbase = {d[31:5], 5'd0}; menq = mbase; mdeq = mbase; end
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic accept(input logic err);
    int w = 0;
    while (!tx_valid && w < 60) begin @(negedge clk); w++; end
    chk("R6 tx_valid offered", {31'd0, tx_valid}, 32'd1);
    if (tx_valid) begin
      chk("R6 src", tx_src_addr, memf(mdeq + 4));
      chk("R6 dest", {16'd0, tx_dest_id}, {16'd0, memf(mdeq + 8) >> 16});
      chk("R6 mbox", {30'd0, tx_mbox}, {30'd0, memf(mdeq + 8) & 32'h3});
      chk("R6 attr", tx_attr, memf(mdeq + 12));
      chk("R6 size", tx_size, memf(mdeq + 24));
      tx_ready = 1; tx_err = err;
      mdeq = mnxt(mdeq);
      if (err) mst[7] = 1; else mst[1] = 1;
      if (mdeq == menq) mst[0] = 1;
      @(negedge clk);
      tx_ready = 0; tx_err = 0;
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);

    wr(2'd2, 32'h1000_005F);
    check_all("R2 base load");
    chk("R2 base aligned", enq_ptr_o, 32'h1000_0040);
    wr(2'd0, 32'h0000_0001);
    check_all("R3 enable");
    wr(2'd0, 32'h0000_0003);
    check_all("R3 increment");
    chk("R3 enq step", enq_ptr_o, 32'h1000_0060);
    accept(0);
    check_all("R7 R8 accept empties");
    wr(2'd1, 32'hFFFF_FFFF);
    check_all("R9 w1c");
    wr(2'd2, 32'h5555_5500);
    check_all("R2 ignored while enabled");
    wr(2'd0, 32'h0000_0002);
    check_all("R3 increment with enable low ignored");
    wr(2'd0, 32'h0000_0001);

    wr(2'd0, 32'h0000_0003);
    wr(2'd0, 32'h0000_0003);
    check_all("R4 fill");
    wr(2'd0, 32'h0000_0003);
    check_all("R5 queue full");
    chk("R4 enq wrapped", enq_ptr_o, 32'h1000_0040);
    chk("R5 qf bit", {31'd0, status_o[4]}, 32'd1);
    wr(2'd0, 32'h0000_0003);
    check_all("R5 overflow");
    chk("R5 qo bit", {31'd0, status_o[5]}, 32'd1);

    while (!tx_valid) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7 tx_valid held", {31'd0, tx_valid}, 32'd1);
    check_all("R7 no advance without ready");
    accept(0);
    check_all("R7 eom");
    accept(1);
    check_all("R7 te");
    accept(0);
    check_all("R8 drained");
    chk("R4 deq wrapped", deq_ptr_o, 32'h1000_0040);
    wr(2'd1, 32'h0000_0012);
    check_all("R9 partial clear");

    wr(2'd0, 32'h0000_1000);
    wr(2'd2, 32'h2000_0000);
    wr(2'd0, 32'h0000_1001);
    wr(2'd1, 32'hFF);
    check_all("R3 size 8");
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 5);
      if (r <= 1) wr(2'd0, 32'h0000_1003);
      else if (r <= 3 && tx_valid) accept($urandom_range(0, 5) == 0);
      else if (r == 4 && $urandom_range(0, 3) == 0) wr(2'd1, $urandom);
      else @(negedge clk);
      check_all("R4/R5/R7/R8/R9 random");
    end
    report();
  end
endmodule